// File: doc/BRIEF.md
# Dual-Alias Enable Register with Change Strobes

This block holds a 32-bit word of per-source enable fields. The word can be reached at two bus addresses. A write to the set address merges the written ones into the word. A write to the clear address knocks the written ones out of it. If only one of the two addresses is configured, that address behaves as an ordinary register and each write replaces the word. Either address returns the stored word on a read. Each address is decoded on its low 29 bits only, so the same register also answers at mirror windows that differ in the upper three address bits.

Each write is followed by a field-by-field comparison of the old word against the new one. Every changed field is reported on a strobe port, one field per cycle, starting with the most significant field. The strobe carries the source identifier of that field and an enable flag. The flag is set when the new field value is nonzero. The identifiers are set per field by a parameter. A field whose identifier is 0 is reserved and never produces a strobe. The field width is also a parameter: a width of 1 gives a plain mask register, and wider fields give priority-style registers. A downstream enable counter consumes the strobes.

A small state machine issues the strobes. It has two states. ST_IDLE waits for writes. ST_EMIT issues one pending strobe per cycle. The machine has three transitions:
- load: ST_IDLE goes to ST_EMIT when an accepted write changes at least one non-reserved field.
- stay: the machine remains in ST_EMIT while strobes are still pending.
- drain: ST_EMIT goes back to ST_IDLE in the cycle that issues the last pending strobe.

While the machine is in ST_EMIT, new writes are held off. Reads are still served.

Top module: `alias_enable_reg`

## Requirements
- R1: After reset the stored word equals RESET_VAL (default 0), no strobe is valid and `bus_ready` is high.
- R2: Addresses are matched on bits [28:0] only. An address that differs from a configured address only in bits [31:29] reaches the same register.
- R3: In dual mode (both addresses nonzero), an accepted write to the set address stores old OR wdata.
- R4: In dual mode, an accepted write to the clear address stores old AND NOT wdata.
- R5: In single mode (CLR_ADDR = 0), an accepted write to SET_ADDR stores wdata unchanged.
- R6: While `bus_valid` is high with `bus_write` low, `bus_rdata` shows the stored word in the same cycle if the address matches either alias, and 0 otherwise. A write to a non-matching address changes nothing and produces no strobe.
- R7: After an accepted write, one strobe per changed field is issued on consecutive cycles, starting the cycle after acceptance. The order runs from the highest field index to the lowest. Field k occupies bits [k*FIELD_W +: FIELD_W].
- R8: `strb_enable` is 1 when the new value of the reported field is nonzero and 0 when it is zero. A change from one nonzero value to another gives an enable strobe.
- R9: A field whose identifier in FIELD_IDS (bits [k*ID_W +: ID_W]) is 0 never produces a strobe. No strobe ever carries identifier 0.
- R10: While strobes are outstanding, `bus_ready` is low for writes, the stored word holds, and reads are still accepted. A write that changes no non-reserved field leaves the machine idle, with `bus_ready` high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Request address |
| bus_wdata | input | DATA_W | Write data |
| bus_ready | output | 1 | Request accepted this cycle |
| bus_rdata | output | DATA_W | Read data, same cycle |
| strb_valid | output | 1 | A field-change strobe is presented |
| strb_enable | output | 1 | 1 = field became nonzero, 0 = became zero |
| strb_id | output | ID_W | Source identifier of the changed field |

## Verification
The assertions assume a requester that keeps a write's address and data steady until `bus_ready` is seen high. They also assume a strobe consumer that never back-pressures, since the strobe port has no ready. The stimulus meets both assumptions:
- Its driver holds each request across stalled cycles and drops `bus_valid` only after the accepting edge.
- Every strobe is taken on the cycle it appears.
- Reads are issued only between writes, or deliberately during an emit burst to exercise R10.

// File: rtl/aer_pkg.sv
package aer_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        WM_NONE,
        WM_SET,
        WM_CLR,
        WM_PLAIN
    } wr_mode_e;

    localparam logic [31:0] ALIAS_MASK = 32'h1FFF_FFFF;
endpackage

// File: rtl/aer_addr_decode.sv
module aer_addr_decode
    import aer_pkg::*;
#(
    parameter logic [31:0] SET_ADDR = 32'h0400_0040,
    parameter logic [31:0] CLR_ADDR = 32'h0400_0044
) (
    input  logic [31:0] addr,
    output wr_mode_e    mode,
    output logic        hit
);
    localparam bit DUAL = (SET_ADDR != 32'h0) && (CLR_ADDR != 32'h0);
    localparam logic [31:0] SET_M = SET_ADDR & ALIAS_MASK;
    localparam logic [31:0] CLR_M = CLR_ADDR & ALIAS_MASK;

    logic [31:0] a_m;
    logic        set_hit, clr_hit;

    assign a_m     = addr & ALIAS_MASK;
    assign set_hit = (SET_ADDR != 32'h0) && (a_m == SET_M);
    assign clr_hit = (CLR_ADDR != 32'h0) && (a_m == CLR_M);
    assign hit     = set_hit || clr_hit;

    generate
        if (DUAL) begin : g_dual
            always_comb begin
                if (set_hit)      mode = WM_SET;
                else if (clr_hit) mode = WM_CLR;
                else              mode = WM_NONE;
            end
        end else begin : g_single
            always_comb mode = hit ? WM_PLAIN : WM_NONE;
        end
    endgenerate
endmodule

// File: rtl/aer_field_diff.sv
module aer_field_diff #(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int ID_W    = 8,
    localparam int NF     = DATA_W / FIELD_W,
    parameter logic [NF*ID_W-1:0] FIELD_IDS = '0
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] new_val,
    output logic [NF-1:0]     change,
    output logic [NF-1:0]     old_nz
);
    generate
        for (genvar k = 0; k < NF; k++) begin : g_fld
            localparam logic [ID_W-1:0] FID = FIELD_IDS[k*ID_W +: ID_W];
            logic [FIELD_W-1:0] f_old, f_new;
            assign f_old     = old_val[k*FIELD_W +: FIELD_W];
            assign f_new     = new_val[k*FIELD_W +: FIELD_W];
            assign change[k] = (FID != '0) && (f_old != f_new);
            assign old_nz[k] = |f_old;
        end
    endgenerate
endmodule

// File: rtl/aer_strobe_seq.sv
module aer_strobe_seq
    import aer_pkg::*;
#(
    parameter int NF = 8,
    localparam int IDX_W = (NF > 1) ? $clog2(NF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NF-1:0]    load_mask,
    output logic             strb_valid,
    output logic [IDX_W-1:0] strb_idx,
    output logic             busy
);
    seq_state_e    state, state_d;
    logic [NF-1:0] pending, pending_d;
    logic [IDX_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NF; i++)
            if (pending[i]) pick = IDX_W'(i);
    end

    always_comb begin
        state_d   = state;
        pending_d = pending;
        unique case (state)
            ST_IDLE: begin
                if (load && (|load_mask)) begin
                    pending_d = load_mask;
                    state_d   = ST_EMIT;
                end
            end
            ST_EMIT: begin
                pending_d = pending & ~(NF'(1) << pick);
                if (pending_d == '0) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pending <= '0;
        end else begin
            state   <= state_d;
            pending <= pending_d;
        end
    end

    always_comb begin
        strb_valid = (state == ST_EMIT);
        busy       = (state == ST_EMIT);
        strb_idx   = pick;
    end

    // R7
    drain_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT) |=> ($countones(pending) == $countones($past(pending)) - 1));

    // R7
    emit_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_valid |-> (pending != '0));
endmodule

// File: rtl/alias_enable_reg.sv
module alias_enable_reg
    import aer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    parameter int ID_W    = 8,
    localparam int NF     = DATA_W / FIELD_W,
    localparam int IDX_W  = (NF > 1) ? $clog2(NF) : 1,
    parameter logic [NF*ID_W-1:0] FIELD_IDS = 64'h1B1A_1918_1700_1514,
    parameter logic [31:0] SET_ADDR  = 32'h0400_0040,
    parameter logic [31:0] CLR_ADDR  = 32'h0400_0044,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [31:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              strb_valid,
    output logic              strb_enable,
    output logic [ID_W-1:0]   strb_id
);
    wr_mode_e          mode;
    logic              hit, busy, wr_acc;
    logic [DATA_W-1:0] value, new_val;
    logic [NF-1:0]     change, old_nz;
    logic [IDX_W-1:0]  strb_idx;

    aer_addr_decode #(.SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
        .addr (bus_addr),
        .mode (mode),
        .hit  (hit)
    );

    always_comb begin
        unique case (mode)
            WM_SET:   new_val = value | bus_wdata;
            WM_CLR:   new_val = value & ~bus_wdata;
            WM_PLAIN: new_val = bus_wdata;
            default:  new_val = value;
        endcase
    end

    aer_field_diff #(
        .DATA_W(DATA_W), .FIELD_W(FIELD_W), .ID_W(ID_W), .FIELD_IDS(FIELD_IDS)
    ) u_diff (
        .old_val (value),
        .new_val (new_val),
        .change  (change),
        .old_nz  (old_nz)
    );

    assign bus_ready = !(busy && bus_write);
    assign wr_acc    = bus_valid && bus_write && bus_ready && hit;
    assign bus_rdata = (bus_valid && !bus_write && hit) ? value : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)      value <= RESET_VAL;
        else if (wr_acc) value <= new_val;
    end

    aer_strobe_seq #(.NF(NF)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_acc),
        .load_mask  (change),
        .strb_valid (strb_valid),
        .strb_idx   (strb_idx),
        .busy       (busy)
    );

    assign strb_id     = FIELD_IDS[strb_idx*ID_W +: ID_W];
    assign strb_enable = old_nz[strb_idx];

    // R3
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && mode == WM_SET) |=> (value == ($past(value) | $past(bus_wdata))));

    // R4
    clr_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && mode == WM_CLR) |=> (value == ($past(value) & ~$past(bus_wdata))));

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_valid && bus_valid && bus_write) |-> !bus_ready);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_valid |=> $stable(value));

    // R9
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_valid |-> (strb_id != '0));
endmodule

// File: tb/alias_enable_reg_tb.sv
module alias_enable_reg_tb;
    localparam int CLK_P = 10;

    function automatic logic [255:0] mk_ids();
        logic [255:0] r;
        for (int i = 0; i < 32; i++) r[i*8 +: 8] = (i == 5) ? 8'h00 : 8'(i + 1);
        return r;
    endfunction

    localparam logic [31:0] A_SET = 32'h0400_0040;
    localparam logic [31:0] A_CLR = 32'h0400_0044;
    localparam logic [31:0] B_ADR = 32'h0400_0080;
    localparam logic [63:0] A_IDS = 64'h1B1A_1918_1700_1514;

    logic clk = 0, rst_n = 0;
    always #(CLK_P/2) clk = ~clk;

    logic a_valid = 0, a_write = 0, a_ready, a_sv, a_se;
    logic [31:0] a_addr = 0, a_wdata = 0, a_rdata;
    logic [7:0]  a_sid;
    logic b_valid = 0, b_write = 0, b_ready, b_sv, b_se;
    logic [31:0] b_addr = 0, b_wdata = 0, b_rdata;
    logic [7:0]  b_sid;

    alias_enable_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(a_valid), .bus_write(a_write),
        .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_ready(a_ready),
        .bus_rdata(a_rdata), .strb_valid(a_sv), .strb_enable(a_se), .strb_id(a_sid));

    alias_enable_reg #(.FIELD_W(1), .FIELD_IDS(mk_ids()), .SET_ADDR(B_ADR),
                       .CLR_ADDR(32'h0)) u_dut_single (
        .clk(clk), .rst_n(rst_n), .bus_valid(b_valid), .bus_write(b_write),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_ready(b_ready),
        .bus_rdata(b_rdata), .strb_valid(b_sv), .strb_enable(b_se), .strb_id(b_sid));

    int vec = 0, bad = 0, b_cnt = 0;
    logic [8:0] exp_q[$];
    logic [31:0] mirror = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every strobe of the main instance
    always @(negedge clk) begin
        if (rst_n && a_sv) begin
            if (exp_q.size() == 0) chk(0, "R7 unexpected strobe", {23'h0, a_sid, a_se}, 32'h0);
            else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({a_sid, a_se} == e, "R7/R8/R9 strobe", {23'h0, a_sid, a_se}, {23'h0, e});
            end
        end
        if (rst_n && b_sv) b_cnt++;
    end

    task automatic wr_a(input logic [31:0] adr, input logic [31:0] d);
        logic [31:0] nv;
        if ((adr & 32'h1FFF_FFFF) == (A_SET & 32'h1FFF_FFFF))      nv = mirror | d;
        else if ((adr & 32'h1FFF_FFFF) == (A_CLR & 32'h1FFF_FFFF)) nv = mirror & ~d;
        else nv = mirror;
        for (int f = 7; f >= 0; f--) begin
            if (mirror[f*4 +: 4] != nv[f*4 +: 4] && A_IDS[f*8 +: 8] != 8'h0)
                exp_q.push_back({A_IDS[f*8 +: 8], |nv[f*4 +: 4]});
        end
        mirror = nv;
        a_valid = 1; a_write = 1; a_addr = adr; a_wdata = d;
        forever begin
            #1;
            if (a_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        a_valid = 0; a_write = 0;
    endtask

    task automatic rd_a(input logic [31:0] adr, input logic [31:0] exp, input string req);
        a_valid = 1; a_write = 0; a_addr = adr;
        #1;
        chk(a_rdata == exp, req, a_rdata, exp);
        @(negedge clk);
        a_valid = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr_b(input logic [31:0] adr, input logic [31:0] d);
        b_valid = 1; b_write = 1; b_addr = adr; b_wdata = d;
        forever begin
            #1;
            if (b_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        b_valid = 0; b_write = 0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(a_sv == 0, "R1 strobe idle", {31'h0, a_sv}, 0);
        chk(a_ready == 1, "R1 ready", {31'h0, a_ready}, 1);
        rd_a(A_SET, 32'h0, "R1 reset value");

        // R3 set write; f2 carries reserved id (R9)
        wr_a(A_SET, 32'h0000_0305);
        drain();
        // R2 mirror window on the set alias; R7 ordering f7 before f1
        wr_a(32'hA400_0040, 32'h7000_0020);
        drain();
        // R6 read through a mirrored clear alias
        rd_a(32'hE400_0044, 32'h7000_0325, "R6 read via clear alias");
        // R8 nonzero to nonzero gives enable
        wr_a(A_SET, 32'h0000_0040);
        drain();
        // R4 clear write
        wr_a(A_CLR, 32'h7000_0005);
        drain();
        rd_a(A_SET, 32'h0000_0360, "R4 value after clear");

        // R10 no-change write stays idle
        wr_a(A_SET, 32'h0000_0020);
        chk(a_sv == 0 && a_ready == 1, "R10 idle after no-change write", {30'h0, a_sv, a_ready}, 1);

        // R10 busy behaviour: strobes for f6 and f5
        wr_a(A_SET, 32'h0FF0_0000);
        a_valid = 1; a_write = 0; a_addr = A_SET;
        #1;
        chk(a_ready == 1 && a_rdata == 32'h0FF0_0360, "R10 read during emit", a_rdata, 32'h0FF0_0360);
        a_write = 1; a_wdata = 32'hFFFF_FFFF;
        #1;
        chk(a_ready == 0, "R10 write stalled", {31'h0, a_ready}, 0);
        a_valid = 0; a_write = 0;
        drain();
        rd_a(A_SET, 32'h0FF0_0360, "R10 value held");

        // R6 non-matching address: no change, read returns 0
        wr_a(32'h0400_0048, 32'hFFFF_FFFF);
        drain();
        chk(exp_q.size() == 0, "R6 no strobe on miss", 32'(exp_q.size()), 0);
        rd_a(32'h0400_0048, 32'h0, "R6 miss reads zero");
        rd_a(A_SET, 32'h0FF0_0360, "R6 value after miss");

        // R5 single mode, 1-bit fields; field 5 reserved
        b_cnt = 0;
        wr_b(B_ADR, 32'h0000_00F0);
        chk(b_cnt == 3, "R5/R9 single-mode strobes", 32'(b_cnt), 3);
        b_cnt = 0;
        wr_b(32'h2400_0080, 32'h0000_003C);
        chk(b_cnt == 4, "R5 replace strobes", 32'(b_cnt), 4);
        b_valid = 1; b_write = 0; b_addr = B_ADR;
        #1;
        chk(b_rdata == 32'h0000_003C, "R5 replaced value", b_rdata, 32'h3C);
        @(negedge clk);
        b_valid = 0;

        chk(exp_q.size() == 0, "R7 all strobes seen", 32'(exp_q.size()), 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            vec++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end
endmodule